// File: doc/BRIEF.md
# Polyphase Resize Table Sequencer

This block produces the ordered list of entries that loads one axis of a polyphase resize lookup table. A controller presents a reduced scaling ratio, an output-size term `i_num` (1 to 31) and an input-size term `i_den`, and pulses `i_start`. The block picks a stepping rule from the ratio. It sends a table-begin marker first. It then sends exactly `i_num` entries. Each entry carries a phase weight on a 512 scale, a source step (offset) and a force-nearest flag. Every word leaves on a valid/ready channel.

The three stepping rules are downscale, integer upscale and fractional upscale. Each rule keeps a running phase accumulator. Downscale and fractional upscale need quotients and remainders, and a small shift-subtract divider supplies them one bit per cycle. The output channel stays idle while the divider works. A 1:1 ratio produces no table and marks that axis as not resized. An out-of-range numerator produces no output and raises an error flag.

Top module: `coef_tbl_seq`

## Requirements
- R1: After an accepted start with a valid, non-unity ratio, the first word offered is the table-begin marker. In the marker `o_marker`=1, and `o_weight`, `o_offset` and `o_nearest` are all ones.
- R2: The mode is chosen from the ratio. Downscale applies when den > num. Integer upscale applies when den == 1. Every other case is fractional upscale, including den == num.
- R3: Exactly num entries follow the marker. After the last entry is accepted, `o_busy` drops and no further word is offered.
- R4: In fractional upscale an accumulator a starts at 0. Each entry has weight = 512 - floor(512*a/num). Then a += den. The offset is 1 and a -= num when a >= num; otherwise the offset is 0. `o_nearest` is 0.
- R5: In integer upscale every entry has weight 512 and `o_nearest`=1. The offset is 1 on the last entry and 0 on every other entry.
- R6: In downscale an accumulator w starts at den. For each entry the steps are, in order: w = num + (w-num) mod 2num; weight = 512 - floor(512*(w-num)/2num); w += 2den; offset = floor((w-num)/2num). `o_nearest` is 0.
- R7: num == 1 with den == 1 emits nothing and clears `o_rsz_en`. Every accepted non-error, non-unity start sets `o_rsz_en`.
- R8: num == 0 or num > 31 sets `o_err` and emits nothing. The next accepted start with a valid ratio clears `o_err`.
- R9: While `o_valid` is high and `i_ready` is low, the offered word stays unchanged on the next cycle.
- R10: A start pulse while `o_busy` is high is ignored. The table in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_start | input | 1 | Start pulse, sampled when idle |
| i_num | input | NUM_W | Reduced ratio numerator (output-size term) |
| i_den | input | DEN_W | Reduced ratio denominator (input-size term) |
| i_ready | input | 1 | Consumer accepts the offered word |
| o_busy | output | 1 | A table is in progress |
| o_valid | output | 1 | A word is offered |
| o_marker | output | 1 | Offered word is the table-begin marker |
| o_weight | output | WT_FRAC+1 | Phase weight, 512 = all of the current source pixel |
| o_offset | output | DEN_W+1 | Source step after this phase |
| o_nearest | output | 1 | Force nearest-neighbour for this phase |
| o_rsz_en | output | 1 | Axis resize enabled by the last accepted ratio |
| o_err | output | 1 | Last start carried an invalid numerator |

## Verification
The assertions check several properties on every cycle. A word held against back-pressure must not change. Every non-marker weight must lie between 1 and 512. A fractional-mode offset must never exceed 1. The divider remainder must stay below its divisor. Each table must begin with the marker, the error flag must keep the block idle, and the block must go idle after the last entry. The exact weight and offset values of each mode come only from the bench's scenarios, which compare every word against an independent model. The same holds for the 1:1 and error outcomes and for the rejection of a start while busy.

// File: rtl/coef_seq_pkg.sv
package coef_seq_pkg;
   typedef enum logic [1:0] {
      MODE_FRAC = 2'd0,
      MODE_INT  = 2'd1,
      MODE_DOWN = 2'd2
   } scl_mode_e;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_MARK = 3'd1,
      S_INIT = 3'd2,
      S_PREP = 3'd3,
      S_WDIV = 3'd4,
      S_SDIV = 3'd5,
      S_EMIT = 3'd6
   } seq_state_e;
endpackage

// File: rtl/coef_div.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module coef_div #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DVD_W-1:0] dvd,
   input  logic [DVS_W-1:0] dvs,
   output logic             done,
   output logic [DVD_W-1:0] quo,
   output logic [DVS_W-1:0] rem
);
   localparam int CNT_W = $clog2(DVD_W + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] rem_q, dvs_q;
   logic             done_q;
   logic [DVS_W:0]   trial, diff;
   logic             ge;

   assign trial = {rem_q, quo_q[DVD_W-1]};
   assign ge    = trial >= {1'b0, dvs_q};
   assign diff  = trial - {1'b0, dvs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         done_q <= 1'b0;
      end else if (go) begin
         cnt_q  <= CNT_W'(DVD_W);
         quo_q  <= dvd;
         rem_q  <= '0;
         dvs_q  <= dvs;
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q  <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
         quo_q  <= {quo_q[DVD_W-2:0], ge};
         cnt_q  <= cnt_q - 1'b1;
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done = done_q;
   assign quo  = quo_q;
   assign rem  = rem_q;

   // remainder must end below the divisor (feeds R4/R6 residues)
   p_div_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (rem_q < dvs_q));
endmodule

// File: rtl/coef_mode_sel.sv
// Ratio classification: error, 1:1 bypass, or one of three stepping rules.
module coef_mode_sel
   import coef_seq_pkg::*;
#(
   parameter int NUM_W   = 6,
   parameter int DEN_W   = 12,
   parameter int MAX_ENT = 31
) (
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             bad,
   output logic             bypass,
   output scl_mode_e        mode
);
   localparam logic [NUM_W-1:0] MAX_V = NUM_W'(MAX_ENT);

   always_comb begin
      bad    = (num == '0) || (num > MAX_V);
      bypass = (num == NUM_W'(1)) && (den == DEN_W'(1));
      if (den > DEN_W'(num))
         mode = MODE_DOWN;
      else if (den == DEN_W'(1))
         mode = MODE_INT;
      else
         mode = MODE_FRAC;
   end
endmodule

// File: rtl/coef_tbl_seq.sv
module coef_tbl_seq
   import coef_seq_pkg::*;
#(
   parameter int NUM_W   = 6,
   parameter int DEN_W   = 12,
   parameter int MAX_ENT = 31,
   parameter int WT_FRAC = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_start,
   input  logic [NUM_W-1:0]     i_num,
   input  logic [DEN_W-1:0]     i_den,
   input  logic                 i_ready,
   output logic                 o_busy,
   output logic                 o_valid,
   output logic                 o_marker,
   output logic [WT_FRAC:0]     o_weight,
   output logic [DEN_W:0]       o_offset,
   output logic                 o_nearest,
   output logic                 o_rsz_en,
   output logic                 o_err
);
   localparam int WT_W  = WT_FRAC + 1;
   localparam int OFF_W = DEN_W + 1;
   localparam int DVS_W = NUM_W + 1;
   localparam int R_W   = DVS_W;
   localparam int DV_A  = DVS_W + WT_FRAC;
   localparam int DV_B  = DEN_W + 2;
   localparam int DVD_W = (DV_A > DV_B) ? DV_A : DV_B;
   localparam logic [WT_W-1:0] ONE = {1'b1, {WT_FRAC{1'b0}}};

   generate
      if (MAX_ENT >= (1 << NUM_W)) begin : g_chk_ent
         $error("MAX_ENT does not fit NUM_W");
      end
      if (DEN_W < DVS_W) begin : g_chk_den
         $error("DEN_W must be at least NUM_W+1");
      end
      if (WT_FRAC < 2) begin : g_chk_wt
         $error("WT_FRAC too small");
      end
   endgenerate

   seq_state_e           st_q;
   scl_mode_e            mode_q, ms_mode;
   logic                 ms_bad, ms_bypass;
   logic [NUM_W-1:0]     num_q, idx_q;
   logic [DEN_W-1:0]     den_q;
   logic [R_W-1:0]       r_q;
   logic [WT_W-1:0]      wt_q;
   logic [OFF_W-1:0]     off_q;
   logic                 near_q, rsz_q, err_q, go_q;
   logic [DVD_W-1:0]     dvd_q, dv_quo;
   logic [DVS_W-1:0]     dvs_q, dv_rem;
   logic                 dv_done;
   logic [DVS_W-1:0]     num2, num_x;
   logic [DEN_W+1:0]     frac_sum, frac_nx;
   logic                 frac_ge, last;

   coef_mode_sel #(.NUM_W(NUM_W), .DEN_W(DEN_W), .MAX_ENT(MAX_ENT)) u_sel (
      .num(i_num), .den(i_den), .bad(ms_bad), .bypass(ms_bypass), .mode(ms_mode));

   coef_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(go_q), .dvd(dvd_q), .dvs(dvs_q),
      .done(dv_done), .quo(dv_quo), .rem(dv_rem));

   assign num2     = {num_q, 1'b0};
   assign num_x    = {1'b0, num_q};
   assign last     = (idx_q == num_q - 1'b1);
   assign frac_sum = (DEN_W+2)'(r_q) + (DEN_W+2)'(den_q);
   assign frac_ge  = frac_sum >= (DEN_W+2)'(num_q);
   assign frac_nx  = frac_sum - (DEN_W+2)'(num_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         mode_q <= MODE_FRAC;
         num_q  <= '0;
         den_q  <= '0;
         idx_q  <= '0;
         r_q    <= '0;
         wt_q   <= '0;
         off_q  <= '0;
         near_q <= 1'b0;
         rsz_q  <= 1'b0;
         err_q  <= 1'b0;
         go_q   <= 1'b0;
         dvd_q  <= '0;
         dvs_q  <= '0;
      end else begin
         go_q <= 1'b0;
         case (st_q)
            S_IDLE: if (i_start) begin
               num_q  <= i_num;
               den_q  <= i_den;
               mode_q <= ms_mode;
               idx_q  <= '0;
               if (ms_bad) begin
                  err_q <= 1'b1;
               end else if (ms_bypass) begin
                  err_q <= 1'b0;
                  rsz_q <= 1'b0;
               end else begin
                  err_q <= 1'b0;
                  rsz_q <= 1'b1;
                  st_q  <= S_MARK;
               end
            end
            S_MARK: if (i_ready) begin
               if (mode_q == MODE_DOWN) begin
                  go_q  <= 1'b1;
                  dvd_q <= DVD_W'(den_q) - DVD_W'(num_q);
                  dvs_q <= num2;
                  st_q  <= S_INIT;
               end else begin
                  r_q  <= '0;
                  st_q <= S_PREP;
               end
            end
            S_INIT: if (dv_done) begin
               r_q  <= dv_rem;
               st_q <= S_PREP;
            end
            S_PREP: begin
               if (mode_q == MODE_INT) begin
                  wt_q   <= ONE;
                  near_q <= 1'b1;
                  off_q  <= last ? OFF_W'(1) : '0;
                  st_q   <= S_EMIT;
               end else begin
                  near_q <= 1'b0;
                  go_q   <= 1'b1;
                  dvd_q  <= DVD_W'(r_q) << WT_FRAC;
                  dvs_q  <= (mode_q == MODE_DOWN) ? num2 : num_x;
                  st_q   <= S_WDIV;
               end
            end
            S_WDIV: if (dv_done) begin
               wt_q <= ONE - dv_quo[WT_W-1:0];
               if (mode_q == MODE_DOWN) begin
                  go_q  <= 1'b1;
                  dvd_q <= DVD_W'(r_q) + (DVD_W'(den_q) << 1);
                  dvs_q <= num2;
                  st_q  <= S_SDIV;
               end else begin
                  off_q <= frac_ge ? OFF_W'(1) : '0;
                  r_q   <= frac_ge ? frac_nx[R_W-1:0] : frac_sum[R_W-1:0];
                  st_q  <= S_EMIT;
               end
            end
            S_SDIV: if (dv_done) begin
               off_q <= dv_quo[OFF_W-1:0];
               r_q   <= dv_rem;
               st_q  <= S_EMIT;
            end
            S_EMIT: if (i_ready) begin
               idx_q <= idx_q + 1'b1;
               st_q  <= last ? S_IDLE : S_PREP;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign o_busy    = (st_q != S_IDLE);
   assign o_valid   = (st_q == S_MARK) || (st_q == S_EMIT);
   assign o_marker  = (st_q == S_MARK);
   assign o_weight  = o_marker ? '1 : wt_q;
   assign o_offset  = o_marker ? '1 : off_q;
   assign o_nearest = o_marker | near_q;
   assign o_rsz_en  = rsz_q;
   assign o_err     = err_q;

   p_marker_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_busy) |-> (o_valid && o_marker));
   p_frac_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_marker && mode_q == MODE_FRAC) |-> (o_offset <= OFF_W'(1)));
   p_weight_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_marker) |-> (o_weight != '0 && o_weight <= ONE));
   p_idle_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_marker && i_ready && last) |=> !o_busy);
   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      o_err |-> !o_busy);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !i_ready) |=> (o_valid && $stable(o_marker) && $stable(o_weight)
                                 && $stable(o_offset) && $stable(o_nearest)));
endmodule

// File: tb/coef_tbl_seq_tb.sv
module coef_tbl_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_W = 6;
   localparam int DEN_W = 12;
   localparam int WT_ONES  = 1023;
   localparam int OFF_ONES = 8191;

   logic clk = 1'b0, rst_n = 1'b0, i_start = 1'b0, i_ready = 1'b0;
   logic [NUM_W-1:0] i_num = '0;
   logic [DEN_W-1:0] i_den = '0;
   logic o_busy, o_valid, o_marker, o_nearest, o_rsz_en, o_err;
   logic [9:0] o_weight;
   logic [DEN_W:0] o_offset;

   int total = 0, bad = 0;
   bit qm[$]; int qw[$]; int qo[$]; bit qn[$]; string qt[$];
   bit ready_all = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   bit hv = 1'b0; int hw, ho; bit hn, hm;

   always #(CLK_PERIOD/2) clk = ~clk;

   coef_tbl_seq u_dut (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_num(i_num), .i_den(i_den),
      .i_ready(i_ready), .o_busy(o_busy), .o_valid(o_valid), .o_marker(o_marker),
      .o_weight(o_weight), .o_offset(o_offset), .o_nearest(o_nearest),
      .o_rsz_en(o_rsz_en), .o_err(o_err));

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(bit m, int w, int o, bit n, string t);
      qm.push_back(m); qw.push_back(w); qo.push_back(o); qn.push_back(n); qt.push_back(t);
   endtask

   // independent model of the table contents (R1, R2, R4, R5, R6)
   task automatic model(int num, int den, string tag);
      int a;
      push(1'b1, WT_ONES, OFF_ONES, 1'b1, "R1");
      if (den > num) begin
         a = den;
         for (int i = 0; i < num; i++) begin
            int w, o;
            a = num + (a - num) % (2 * num);
            w = 512 - (512 * (a - num)) / (2 * num);
            a = a + 2 * den;
            o = (a - num) / (2 * num);
            push(1'b0, w, o & OFF_ONES, 1'b0, tag);
         end
      end else if (den == 1) begin
         for (int i = 0; i < num; i++)
            push(1'b0, 512, (i == num - 1) ? 1 : 0, 1'b1, tag);
      end else begin
         a = 0;
         for (int i = 0; i < num; i++) begin
            int w, o;
            w = 512 - (512 * a) / num;
            a = a + den;
            o = (a >= num) ? 1 : 0;
            if (o == 1) a = a - num;
            push(1'b0, w, o, 1'b0, tag);
         end
      end
   endtask

   task automatic run(int num, int den, string tag, bit intr);
      if (!(num == 0 || num > 31) && !(num == 1 && den == 1)) model(num, den, tag);
      @(negedge clk);
      i_start = 1'b1; i_num = NUM_W'(num); i_den = DEN_W'(den);
      @(negedge clk);
      i_start = 1'b0;
      repeat (3) @(negedge clk);
      if (intr && o_busy) begin
         // R10: start during a busy table must be ignored
         i_start = 1'b1; i_num = 6'd0; i_den = 12'd9;
         @(negedge clk);
         i_start = 1'b0;
         @(negedge clk);
         chk(o_err == 1'b0, "R10", "err after busy start", int'(o_err), 0);
      end
      while (o_busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(qm.size() == 0, "R3", "entries missing", qm.size(), 0);
      qm.delete(); qw.delete(); qo.delete(); qn.delete(); qt.delete();
   endtask

   task automatic finish_up;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      i_ready <= ready_all | lfsr[0] | lfsr[3];
   end

   // scoreboard monitor, samples between edges
   always @(negedge clk) begin
      if (rst_n) begin
         if (hv && o_valid)
            chk(o_weight == hw[9:0] && o_offset == ho[12:0] && o_nearest == hn
                && o_marker == hm, "R9", "held word changed", int'(o_weight), hw);
         else if (hv)
            chk(1'b0, "R9", "valid dropped under stall", 0, 1);
         hv = o_valid && !i_ready;
         hw = int'(o_weight); ho = int'(o_offset); hn = o_nearest; hm = o_marker;
         if (o_valid && i_ready) begin
            if (qm.size() == 0) begin
               chk(1'b0, "R3", "unexpected word", int'(o_weight), -1);
            end else begin
               bit m, n; int w, o; string t;
               m = qm.pop_front(); w = qw.pop_front(); o = qo.pop_front();
               n = qn.pop_front(); t = qt.pop_front();
               chk(o_marker == m, t, "marker", int'(o_marker), int'(m));
               chk(int'(o_weight) == w, t, "weight", int'(o_weight), w);
               chk(int'(o_offset) == o, t, "offset", int'(o_offset), o);
               chk(o_nearest == n, t, "nearest", int'(o_nearest), int'(n));
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", "run hung", 0, 1);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!o_valid && !o_busy, "R3", "reset idle", int'(o_valid), 0);
      chk(!o_err && !o_rsz_en, "R7", "reset flags", int'(o_rsz_en), 0);

      run(5, 3, "R4", 1'b0);
      chk(o_rsz_en == 1'b1, "R7", "rsz_en after table", int'(o_rsz_en), 1);
      run(4, 1, "R5", 1'b0);
      run(3, 8, "R6", 1'b0);
      run(7, 7, "R2", 1'b0);
      run(2, 3, "R2", 1'b0);
      run(1, 1, "R7", 1'b0);
      chk(o_rsz_en == 1'b0, "R7", "rsz_en after 1:1", int'(o_rsz_en), 0);
      chk(o_err == 1'b0, "R7", "no err on 1:1", int'(o_err), 0);
      run(0, 5, "R8", 1'b0);
      chk(o_err == 1'b1, "R8", "err on num 0", int'(o_err), 1);
      run(32, 3, "R8", 1'b0);
      chk(o_err == 1'b1, "R8", "err on num 32", int'(o_err), 1);
      run(63, 70, "R8", 1'b0);
      chk(o_err == 1'b1, "R8", "err on num 63", int'(o_err), 1);
      run(3, 5, "R6", 1'b0);
      chk(o_err == 1'b0, "R8", "err cleared", int'(o_err), 0);
      ready_all = 1'b1;
      run(31, 30, "R4", 1'b0);
      ready_all = 1'b0;
      run(31, 1, "R5", 1'b0);
      run(2, 4095, "R6", 1'b0);
      run(31, 64, "R6", 1'b0);
      run(6, 5, "R10", 1'b1);
      run(5, 17, "R10", 1'b1);
      finish_up();
   end
endmodule